// File: doc/BRIEF.md
# Shift and Rotate Register with Carry

This block is an N-bit clocked register that moves its contents by one bit position per clock, or holds them, or takes a new word in parallel. A 4-bit operation code picks the action. The shift actions are logical right, arithmetic right, and left. The rotate actions are plain rotates in either direction and rotates in either direction through a one-bit carry flag. Two further codes shift in a bit from outside the block. Whenever a bit leaves the register on a shift or rotate, that bit is written to the carry flag.

Each end of the register has a serial input and a serial output, so several sections can be chained into one wider register. The serial outputs are combinational copies of the current end bits. A neighbouring section driven with the same code therefore samples them on the same clock edge. When two sections get the external shift codes, they behave as a single register twice as wide.

Top module: `shift_rot_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q` and `carry` both become 0 after that edge, whatever the value of `op`.
- R2: Code 0 keeps `q` and `carry` unchanged. So does every code from 11 to 15.
- R3: Code 1 writes `parIn` into `q`. `carry` stays unchanged.
- R4: Code 2 (logical right) sets `q` to the old `q` shifted toward bit 0, with 0 entering bit WIDTH-1. `carry` takes the old bit 0.
- R5: Code 3 (arithmetic right) moves `q` toward bit 0 while bit WIDTH-1 keeps its old value. `carry` takes the old bit 0.
- R6: Code 4 (left shift, the same for logical and arithmetic) moves `q` toward bit WIDTH-1, with 0 entering bit 0. `carry` takes the old bit WIDTH-1.
- R7: Code 5 (rotate right) writes the old bit 0 into bit WIDTH-1. Code 6 (rotate left) writes the old bit WIDTH-1 into bit 0. In both cases `carry` takes the bit that wrapped around.
- R8: Code 7 (rotate right through carry) writes the old `carry` into bit WIDTH-1, and `carry` takes the old bit 0. Code 8 (rotate left through carry) writes the old `carry` into bit 0, and `carry` takes the old bit WIDTH-1.
- R9: Code 9 moves `q` toward bit 0, with `serInLeft` entering bit WIDTH-1. Code 10 moves `q` toward bit WIDTH-1, with `serInRight` entering bit 0. In both cases `carry` takes the bit that leaves the register.
- R10: `serOutLeft` always equals bit WIDTH-1 of `q`, and `serOutRight` always equals bit 0. Two sections chained through these pins act as one 2*WIDTH-bit register under codes 1, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code (see R2 to R9) |
| parIn | input | WIDTH | Parallel load word |
| serInLeft | input | 1 | Bit entering the top end on code 9 |
| serInRight | input | 1 | Bit entering the bottom end on code 10 |
| serOutLeft | output | 1 | Current bit WIDTH-1 of the register |
| serOutRight | output | 1 | Current bit 0 of the register |
| q | output | WIDTH | Register contents |
| carry | output | 1 | Carry flag |

## Verification
An operation code that is present before a rising edge shows up in `q` and `carry` just after that edge, one cycle later. There is one register between the input and the output. The serial outputs follow `q` in the same cycle, with no extra delay. The bench changes its inputs 1 ns after a rising edge, then waits for the next rising edge. It samples 1 ns after that edge and compares against a model built from the requirements. Chaining is checked with two 4-bit sections that share one code. Their combined 8-bit word is compared after every edge.

// File: rtl/srr_pkg.sv
package srr_pkg;

  localparam logic [3:0] OP_HOLD = 4'd0;
  localparam logic [3:0] OP_LOAD = 4'd1;
  localparam logic [3:0] OP_LSR  = 4'd2;
  localparam logic [3:0] OP_ASR  = 4'd3;
  localparam logic [3:0] OP_SHL  = 4'd4;
  localparam logic [3:0] OP_ROR  = 4'd5;
  localparam logic [3:0] OP_ROL  = 4'd6;
  localparam logic [3:0] OP_RRC  = 4'd7;
  localparam logic [3:0] OP_RLC  = 4'd8;
  localparam logic [3:0] OP_SRX  = 4'd9;
  localparam logic [3:0] OP_SLX  = 4'd10;

  // Per-bit move selection: keep, take from the higher neighbour
  // (content moves down), take from the lower neighbour (moves up), load.
  typedef enum logic [1:0] {
    MV_KEEP = 2'd0,
    MV_DOWN = 2'd1,
    MV_UP   = 2'd2,
    MV_LOAD = 2'd3
  } moveSel_t;

  // Source of the bit written into the vacated end position.
  typedef enum logic [2:0] {
    FILL_ZERO   = 3'd0,
    FILL_SIGN   = 3'd1,
    FILL_WRAP   = 3'd2,
    FILL_CARRY  = 3'd3,
    FILL_SERIAL = 3'd4
  } fillSel_t;

  typedef struct packed {
    moveSel_t move;
    fillSel_t fill;
    logic     carryWe;
  } srrStrobes_t;

endpackage

// File: rtl/srr_control.sv
module srr_control
  import srr_pkg::*;
(
  input  logic [3:0]  op,
  output srrStrobes_t strobes
);

  always_comb begin
    strobes.move    = MV_KEEP;
    strobes.fill    = FILL_ZERO;
    strobes.carryWe = 1'b0;
    case (op)
      OP_LOAD: strobes.move = MV_LOAD;
      OP_LSR: begin
        strobes.move = MV_DOWN;  strobes.fill = FILL_ZERO;   strobes.carryWe = 1'b1;
      end
      OP_ASR: begin
        strobes.move = MV_DOWN;  strobes.fill = FILL_SIGN;   strobes.carryWe = 1'b1;
      end
      OP_SHL: begin
        strobes.move = MV_UP;    strobes.fill = FILL_ZERO;   strobes.carryWe = 1'b1;
      end
      OP_ROR: begin
        strobes.move = MV_DOWN;  strobes.fill = FILL_WRAP;   strobes.carryWe = 1'b1;
      end
      OP_ROL: begin
        strobes.move = MV_UP;    strobes.fill = FILL_WRAP;   strobes.carryWe = 1'b1;
      end
      OP_RRC: begin
        strobes.move = MV_DOWN;  strobes.fill = FILL_CARRY;  strobes.carryWe = 1'b1;
      end
      OP_RLC: begin
        strobes.move = MV_UP;    strobes.fill = FILL_CARRY;  strobes.carryWe = 1'b1;
      end
      OP_SRX: begin
        strobes.move = MV_DOWN;  strobes.fill = FILL_SERIAL; strobes.carryWe = 1'b1;
      end
      OP_SLX: begin
        strobes.move = MV_UP;    strobes.fill = FILL_SERIAL; strobes.carryWe = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/srr_datapath.sv
module srr_datapath
  import srr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  srrStrobes_t      strobes,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serInLeft,
  input  logic             serInRight,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] qReg;
  logic [WIDTH-1:0] qNext;
  logic             carryReg;
  logic             dropBit;
  logic             fillBit;

  // The bit leaving the register is also the wrap-around bit of a rotate.
  always_comb begin
    dropBit = (strobes.move == MV_UP) ? qReg[MSB] : qReg[0];
    case (strobes.fill)
      FILL_SIGN:   fillBit = qReg[MSB];
      FILL_WRAP:   fillBit = dropBit;
      FILL_CARRY:  fillBit = carryReg;
      FILL_SERIAL: fillBit = (strobes.move == MV_UP) ? serInRight : serInLeft;
      default:     fillBit = 1'b0;
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromHigh;
    logic fromLow;
    if (i == MSB) begin : g_top
      assign fromHigh = fillBit;
    end else begin : g_mid_hi
      assign fromHigh = qReg[i+1];
    end
    if (i == 0) begin : g_bot
      assign fromLow = fillBit;
    end else begin : g_mid_lo
      assign fromLow = qReg[i-1];
    end
    always_comb begin
      case (strobes.move)
        MV_DOWN: qNext[i] = fromHigh;
        MV_UP:   qNext[i] = fromLow;
        MV_LOAD: qNext[i] = parIn[i];
        default: qNext[i] = qReg[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qReg     <= '0;
      carryReg <= 1'b0;
    end else begin
      qReg <= qNext;
      if (strobes.carryWe) carryReg <= dropBit;
    end
  end

  assign q     = qReg;
  assign carry = carryReg;

endmodule

// File: rtl/shift_rot_reg.sv
module shift_rot_reg
  import srr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serInLeft,
  input  logic             serInRight,
  output logic             serOutLeft,
  output logic             serOutRight,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  srrStrobes_t strobes;

  srr_control u_ctrl (
    .op      (op),
    .strobes (strobes)
  );

  srr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .parIn      (parIn),
    .serInLeft  (serInLeft),
    .serInRight (serInRight),
    .q          (q),
    .carry      (carry)
  );

  assign serOutLeft  = q[WIDTH-1];
  assign serOutRight = q[0];

endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] parIn,
  input logic             serInLeft,
  input logic             serInRight,
  input logic             serOutLeft,
  input logic             serOutRight,
  input logic [WIDTH-1:0] q,
  input logic             carry
);

  localparam int MSB = WIDTH - 1;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (q == '0) && !carry);

  // R2
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 || op > 4'd10) |=> $stable(q) && $stable(carry));

  // R3
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd1) |=> (q == $past(parIn)) && $stable(carry));

  // R4
  a_r4_lsr: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd2) |=> !q[MSB] && (q[MSB-1:0] == $past(q[MSB:1])) && (carry == $past(q[0])));

  // R5
  a_r5_asr: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd3) |=> (q[MSB] == $past(q[MSB])) && (q[MSB-1:0] == $past(q[MSB:1]))
                     && (carry == $past(q[0])));

  // R8
  a_r8_rrc: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd7) |=> (q[MSB] == $past(carry)) && (carry == $past(q[0])));

  // R9
  a_r9_slx: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd10) |=> (q[0] == $past(serInRight)) && (carry == $past(q[MSB])));

  // R10
  a_r10_serout: assert property (@(posedge clk) disable iff (rst)
    (serOutLeft == q[MSB]) && (serOutRight == q[0]));

endmodule

bind shift_rot_reg srr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op          (op),
  .parIn       (parIn),
  .serInLeft   (serInLeft),
  .serInRight  (serInRight),
  .serOutLeft  (serOutLeft),
  .serOutRight (serOutRight),
  .q           (q),
  .carry       (carry)
);

// File: tb/shift_rot_reg_test.sv
`timescale 1ns/1ps
module shift_rot_reg_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op  = 4'd0;
  logic [W-1:0] parIn = '0;
  logic         serInLeft = 1'b0;
  logic         serInRight = 1'b0;
  logic         serOutLeft, serOutRight, carry;
  logic [W-1:0] q;

  // two 4-bit sections forming one 8-bit register
  logic [3:0] chOp = 4'd0;
  logic [7:0] chPar = '0;
  logic       chInL = 1'b0, chInR = 1'b0;
  logic [3:0] hiQ, loQ;
  logic       hiOutL, hiOutR, loOutL, loOutR, hiC, loC;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] expQ = '0;
  logic         expC = 1'b0;
  logic [7:0]   expChain = '0;

  always #4 clk = ~clk;

  shift_rot_reg #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .op(op), .parIn(parIn),
    .serInLeft(serInLeft), .serInRight(serInRight),
    .serOutLeft(serOutLeft), .serOutRight(serOutRight),
    .q(q), .carry(carry));

  shift_rot_reg #(.WIDTH(4)) chainHi (
    .clk(clk), .rst(rst), .op(chOp), .parIn(chPar[7:4]),
    .serInLeft(chInL), .serInRight(loOutL),
    .serOutLeft(hiOutL), .serOutRight(hiOutR),
    .q(hiQ), .carry(hiC));

  shift_rot_reg #(.WIDTH(4)) chainLo (
    .clk(clk), .rst(rst), .op(chOp), .parIn(chPar[3:0]),
    .serInLeft(hiOutR), .serInRight(chInR),
    .serOutLeft(loOutL), .serOutRight(loOutR),
    .q(loQ), .carry(loC));

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference behaviour written from the requirements: returns {carry, q}.
  function automatic logic [W:0] model(input logic [3:0] o, input logic [W-1:0] v,
                                        input logic c, input logic [W-1:0] p,
                                        input logic sl, input logic sr);
    case (o)
      4'd1:  return {c, p};
      4'd2:  return {v[0], 1'b0, v[W-1:1]};
      4'd3:  return {v[0], v[W-1], v[W-1:1]};
      4'd4:  return {v[W-1], v[W-2:0], 1'b0};
      4'd5:  return {v[0], v[0], v[W-1:1]};
      4'd6:  return {v[W-1], v[W-2:0], v[W-1]};
      4'd7:  return {v[0], c, v[W-1:1]};
      4'd8:  return {v[W-1], v[W-2:0], c};
      4'd9:  return {v[0], sl, v[W-1:1]};
      4'd10: return {v[W-1], v[W-2:0], sr};
      default: return {c, v};
    endcase
  endfunction

  // Drive one operation for one edge, sample 1 ns after that edge.
  task automatic apply(input string tag, input logic [3:0] o, input logic [W-1:0] p,
                       input logic sl, input logic sr);
    logic [W:0] r;
    op = o; parIn = p; serInLeft = sl; serInRight = sr;
    r = model(o, expQ, expC, p, sl, sr);
    @(posedge clk); #1;
    op = 4'd0;
    expQ = r[W-1:0]; expC = r[W];
    check(tag, "q", q, expQ);
    check(tag, "carry", {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, expC});
    check("R10", "serial outs", {{(W-2){1'b0}}, serOutLeft, serOutRight},
          {{(W-2){1'b0}}, expQ[W-1], expQ[0]});
  endtask

  task automatic do_reset();
    rst = 1'b1; op = 4'd1; parIn = 8'hFF;
    chOp = 4'd1; chPar = 8'hFF;
    @(posedge clk); #1;
    rst = 1'b0; op = 4'd0; chOp = 4'd0;
    expQ = '0; expC = 1'b0; expChain = '0;
    check("R1", "q after reset", q, '0);
    check("R1", "carry after reset", {7'd0, carry}, 8'd0);
    check("R1", "chain after reset", {hiQ, loQ}, 8'd0);
  endtask

  task automatic test_load_hold();
    apply("R3", 4'd1, 8'hA5, 1'b0, 1'b0);
    apply("R2", 4'd0, 8'h3C, 1'b1, 1'b1);
    for (int k = 11; k < 16; k++) apply("R2", 4'(k), 8'h5A, 1'b1, 1'b1);
  endtask

  task automatic test_right_shifts();
    apply("R3", 4'd1, 8'h81, 1'b0, 1'b0);
    apply("R4", 4'd2, 8'h00, 1'b1, 1'b1);
    apply("R4", 4'd2, 8'h00, 1'b1, 1'b1);
    apply("R3", 4'd1, 8'h81, 1'b0, 1'b0);
    apply("R5", 4'd3, 8'h00, 1'b0, 1'b0);
    apply("R5", 4'd3, 8'h00, 1'b0, 1'b0);
    apply("R3", 4'd1, 8'h42, 1'b0, 1'b0);
    apply("R5", 4'd3, 8'h00, 1'b1, 1'b1);
  endtask

  task automatic test_left_and_rotates();
    apply("R3", 4'd1, 8'h81, 1'b0, 1'b0);
    apply("R6", 4'd4, 8'h00, 1'b1, 1'b1);
    apply("R6", 4'd4, 8'h00, 1'b1, 1'b1);
    apply("R3", 4'd1, 8'h01, 1'b0, 1'b0);
    apply("R7", 4'd5, 8'h00, 1'b0, 1'b0);
    apply("R7", 4'd5, 8'h00, 1'b0, 1'b0);
    apply("R7", 4'd6, 8'h00, 1'b0, 1'b0);
    apply("R7", 4'd6, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic test_carry_rotates();
    apply("R3", 4'd1, 8'h01, 1'b0, 1'b0);
    apply("R8", 4'd7, 8'h00, 1'b0, 1'b0);
    apply("R8", 4'd7, 8'h00, 1'b0, 1'b0);
    apply("R3", 4'd1, 8'h80, 1'b0, 1'b0);
    apply("R8", 4'd8, 8'h00, 1'b0, 1'b0);
    apply("R8", 4'd8, 8'h00, 1'b0, 1'b0);
    for (int k = 0; k < 9; k++) apply("R8", 4'd7, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic test_serial();
    apply("R3", 4'd1, 8'h0F, 1'b0, 1'b0);
    apply("R9", 4'd9, 8'h00, 1'b1, 1'b0);
    apply("R9", 4'd9, 8'h00, 1'b0, 1'b1);
    apply("R9", 4'd10, 8'h00, 1'b0, 1'b1);
    apply("R9", 4'd10, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic chain_step(input logic [3:0] o, input logic [7:0] p,
                            input logic il, input logic ir);
    chOp = o; chPar = p; chInL = il; chInR = ir;
    case (o)
      4'd1:  expChain = p;
      4'd9:  expChain = {il, expChain[7:1]};
      4'd10: expChain = {expChain[6:0], ir};
      default: ;
    endcase
    @(posedge clk); #1;
    chOp = 4'd0;
    check("R10", "chained word", {hiQ, loQ}, expChain);
  endtask

  task automatic test_chain();
    chain_step(4'd1, 8'hB4, 1'b0, 1'b0);
    chain_step(4'd9, 8'h00, 1'b1, 1'b0);
    chain_step(4'd9, 8'h00, 1'b0, 1'b0);
    chain_step(4'd10, 8'h00, 1'b0, 1'b1);
    chain_step(4'd10, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic test_reset_midrun();
    apply("R3", 4'd1, 8'hFF, 1'b0, 1'b0);
    apply("R4", 4'd2, 8'h00, 1'b0, 1'b0);
    do_reset();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    do_reset();
    test_load_hold();
    test_right_shifts();
    test_left_and_rotates();
    test_carry_rotates();
    test_serial();
    test_chain();
    test_reset_midrun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule